// File: doc/BRIEF.md
# Serial-Bus Control Group Register Writer

This block is a write-only slave for the two-wire serial bus (I2C). It fills a bank of six 8-bit control-group registers. Both bus lines are brought into a faster system clock through synchronisers. The block finds START and STOP conditions and checks the 7-bit device address and the direction bit. It acknowledges by pulling the data line low through an active-low enable, and it never drives the line high.

After the address byte, the first byte picks the group at which writing starts. Each data byte after that lands in the current group, and the group index then steps up by one. A single transaction can therefore update one group, a run of consecutive groups, or all six, depending on where it starts and how many bytes it carries. All group contents are always visible as one flat parallel output, so downstream logic can use them directly.

Top module: `ctlBankI2c`

## Requirements
- R1: While reset is asserted, every group register reads 0x00 and the SDA enable `sdaOeN` is 1 (line released).
- R2: A START (SDA falls while SCL is high) puts the receiver back to expecting an address byte. This holds for a repeated START in the middle of a transaction too. A STOP (SDA rises while SCL is high) ends the transaction.
- R3: An address byte whose upper 7 bits equal `DEV_ADDR` and whose last bit (bit 0, the direction bit) is 0 is acknowledged: `sdaOeN` is 0 while SCL is high during the ninth clock.
- R4: An address byte that does not match, or that has direction bit 1, is not acknowledged. All bytes after it, up to the next START, leave the registers unchanged and get no acknowledge.
- R5: The byte after an accepted address is a group index. Values 0 to 5 are acknowledged and select the first group to write. Values of 6 or more are not acknowledged, and the data bytes that follow are ignored.
- R6: Data bytes are shifted in most significant bit first. Each acknowledged data byte is written to the current group, and the index then advances by one. Starting at group n fills n, n+1, and so on.
- R7: A transaction with a single data byte changes only the addressed group. Any one write changes at most one group.
- R8: Once group 5 has been written, further data bytes are not acknowledged and are discarded.
- R9: A STOP that comes part-way through a byte discards that byte. The group it would have gone to keeps its old value.
- R10: SDA is only ever pulled low, through `sdaOeN`. The pull starts and ends only while synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOeN | output | 1 | Active-low enable that pulls SDA to 0; 1 releases the line |
| grpFlat | output | 48 | Group registers, group k at bits [8k+7:8k] |

## Verification
The bench starts writes at group 0, at group 3 and at group 5. A design with a broken auto-increment would write the wrong group or keep rewriting the same one. It overruns the bank by starting at group 4 and sending three bytes; a design with no upper bound would acknowledge the third byte or wrap around onto group 0. It also sends a wrong address, a read-direction address and an out-of-range group index, then follows each with data bytes that must have no effect. Finally it cuts a byte short with a STOP and issues a repeated START in mid-transaction. A design that committed partial bytes, or that kept its old byte position across a START, would show corrupted group contents at the outputs.

// File: rtl/ctlBankPkg.sv
package ctlBankPkg;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic shiftEn;   // shift one sampled SDA bit into the byte register
    logic loadPtr;   // load the group index from the received byte
    logic writeGrp;  // commit the received byte to the current group
  } ctlStrobeT;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_SUB,
    M_DATA,
    M_SKIP
  } modeT;

  typedef enum logic [1:0] {
    P_RX,    // collecting the eight bits of a byte
    P_HOLD,  // eight bits in, waiting for SCL to fall
    P_ACK    // acknowledge clock in progress
  } phaseT;

endpackage

// File: rtl/ctlBankSync.sv
module ctlBankSync (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int STAGES = 2;

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS    = sclPipe[STAGES-1];
  assign sdaS    = sdaPipe[STAGES-1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/ctlBankFsm.sv
module ctlBankFsm
  import ctlBankPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startEv,
  input  logic      stopEv,
  input  logic      addrHit,
  input  logic      subOk,
  input  logic      ptrOk,
  output ctlStrobeT strobes,
  output logic      sdaOeN,
  output logic      skipMode
);

  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = $clog2(BITS_PER_BYTE);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE - 1);

  modeT  mode;
  phaseT phase;
  logic [CNT_W-1:0] bitCnt;
  logic ackFlag;
  logic rxActive;
  logic busEvent;
  logic ackDecide;
  logic ackEnd;
  modeT modeAfterAck;

  assign busEvent = startEv | stopEv;
  assign rxActive = (mode == M_ADDR) || (mode == M_SUB) || (mode == M_DATA);
  assign ackEnd   = (phase == P_ACK) && sclFall && !busEvent;

  always_comb begin
    case (mode)
      M_ADDR:  ackDecide = addrHit;
      M_SUB:   ackDecide = subOk;
      M_DATA:  ackDecide = ptrOk;
      default: ackDecide = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      M_ADDR:  modeAfterAck = M_SUB;
      M_SUB:   modeAfterAck = M_DATA;
      M_DATA:  modeAfterAck = M_DATA;
      default: modeAfterAck = M_SKIP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= M_IDLE;
      phase   <= P_RX;
      bitCnt  <= '0;
      ackFlag <= 1'b0;
    end else if (stopEv) begin
      mode    <= M_IDLE;
      phase   <= P_RX;
      bitCnt  <= '0;
      ackFlag <= 1'b0;
    end else if (startEv) begin
      mode    <= M_ADDR;
      phase   <= P_RX;
      bitCnt  <= '0;
      ackFlag <= 1'b0;
    end else begin
      case (phase)
        P_RX: begin
          if (sclRise && rxActive) begin
            if (bitCnt == LAST_BIT) begin
              bitCnt  <= '0;
              phase   <= P_HOLD;
              ackFlag <= ackDecide;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        P_HOLD: begin
          if (sclFall) phase <= P_ACK;
        end
        P_ACK: begin
          if (sclFall) begin
            phase   <= P_RX;
            ackFlag <= 1'b0;
            mode    <= ackFlag ? modeAfterAck : M_SKIP;
          end
        end
        default: phase <= P_RX;
      endcase
    end
  end

  always_comb begin
    strobes.shiftEn  = (phase == P_RX) && sclRise && rxActive && !busEvent;
    strobes.loadPtr  = ackEnd && ackFlag && (mode == M_SUB);
    strobes.writeGrp = ackEnd && ackFlag && (mode == M_DATA);
  end

  assign sdaOeN   = !((phase == P_ACK) && ackFlag);
  assign skipMode = (mode == M_SKIP);

endmodule

// File: rtl/ctlBankDatapath.sv
module ctlBankDatapath
  import ctlBankPkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h42,
  parameter int         NUM_GROUPS = 6,
  parameter int         PTR_W      = $clog2(NUM_GROUPS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sdaS,
  input  ctlStrobeT               strobes,
  output logic                    addrHit,
  output logic                    subOk,
  output logic                    ptrOk,
  output logic [PTR_W-1:0]        ptrVal,
  output logic [NUM_GROUPS*8-1:0] grpFlat
);

  localparam logic [7:0]       GRP_LIM = 8'(NUM_GROUPS);
  localparam logic [PTR_W-1:0] PTR_LIM = PTR_W'(NUM_GROUPS);

  logic [7:0] shiftReg;
  logic [7:0] byteNext;
  logic [PTR_W-1:0] ptr;

  assign byteNext = {shiftReg[6:0], sdaS};
  assign addrHit  = (byteNext[7:1] == DEV_ADDR) && !byteNext[0];
  assign subOk    = byteNext < GRP_LIM;
  assign ptrOk    = ptr < PTR_LIM;
  assign ptrVal   = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= byteNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobes.loadPtr) begin
      ptr <= shiftReg[PTR_W-1:0];
    end else if (strobes.writeGrp && ptrOk) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [7:0] grpReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        grpReg <= 8'h00;
      end else if (strobes.writeGrp && (ptr == PTR_W'(g))) begin
        grpReg <= shiftReg;
      end
    end
    assign grpFlat[g*8 +: 8] = grpReg;
  end

endmodule

// File: rtl/ctlBankI2c.sv
module ctlBankI2c
  import ctlBankPkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h42,
  parameter int         NUM_GROUPS = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaOeN,
  output logic [NUM_GROUPS*8-1:0] grpFlat
);

  localparam int PTR_W = $clog2(NUM_GROUPS + 1);

  logic sclSync, sdaSync, sclRise, sclFall, startEv, stopEv;
  logic addrHit, subOk, ptrOk, skipMode;
  logic [PTR_W-1:0] ptrVal;
  ctlStrobeT strobes;

  ctlBankSync sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclSync), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  ctlBankFsm fsm_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .addrHit(addrHit), .subOk(subOk),
    .ptrOk(ptrOk), .strobes(strobes), .sdaOeN(sdaOeN), .skipMode(skipMode)
  );

  ctlBankDatapath #(
    .DEV_ADDR(DEV_ADDR), .NUM_GROUPS(NUM_GROUPS), .PTR_W(PTR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sdaS(sdaSync), .strobes(strobes),
    .addrHit(addrHit), .subOk(subOk), .ptrOk(ptrOk), .ptrVal(ptrVal),
    .grpFlat(grpFlat)
  );

endmodule

// File: rtl/ctlBankI2cChk.sv
module ctlBankI2cChk #(
  parameter int NUM_GROUPS = 6,
  parameter int PTR_W      = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sclSync,
  input logic                    sdaOeN,
  input logic                    skipMode,
  input logic                    wrStrobe,
  input logic [PTR_W-1:0]        ptrVal,
  input logic [NUM_GROUPS*8-1:0] grpFlat
);

  logic [NUM_GROUPS*8-1:0] prevGrp;
  logic [NUM_GROUPS-1:0]   chg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevGrp <= '0;
    else       prevGrp <= grpFlat;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gChg
    assign chg[g] = grpFlat[g*8 +: 8] != prevGrp[g*8 +: 8];
  end

  // R1: reset values
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_state: assert (grpFlat == '0 && sdaOeN == 1'b1);
    end
  end

  // R4: no acknowledge while ignoring the bus
  a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    skipMode |-> sdaOeN);

  // R6: groups change only on a commit strobe
  a_r6_change_needs_commit: assert property (@(posedge clk) disable iff (!rstN)
    (grpFlat != $past(grpFlat)) |-> $past(wrStrobe));

  // R7: at most one group changes at a time
  a_r7_one_group_per_write: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chg) <= 1);

  // R8: pointer bounded, no commit past the last group
  a_r8_ptr_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ptrVal <= PTR_W'(NUM_GROUPS));
  a_r8_no_commit_past_end: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (ptrVal < PTR_W'(NUM_GROUPS)));

  // R10: pull begins and ends only while SCL is low
  a_r10_pull_starts_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOeN) |-> !sclSync);
  a_r10_release_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOeN) |-> !sclSync);

endmodule

bind ctlBankI2c ctlBankI2cChk #(.NUM_GROUPS(NUM_GROUPS), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaOeN(sdaOeN),
  .skipMode(skipMode), .wrStrobe(strobes.writeGrp), .ptrVal(ptrVal),
  .grpFlat(grpFlat)
);

// File: tb/ctlBankI2c_tb_top.sv
module ctlBankI2c_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;            // system clocks per quarter SCL period
  localparam int NG = 6;
  localparam logic [6:0] ADDR = 7'h42;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOeN;
  logic [NG*8-1:0] grpFlat;
  logic sdaLine;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] expG [NG];

  assign sdaLine = sdaM & sdaOeN;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlBankI2c #(.DEV_ADDR(ADDR), .NUM_GROUPS(NG)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOeN(sdaOeN), .grpFlat(grpFlat)
  );

  task automatic waitQ(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkBank(string tag);
    for (int g = 0; g < NG; g++)
      check(grpFlat[g*8 +: 8] == expG[g], tag, 64'(grpFlat[g*8 +: 8]), 64'(expG[g]));
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendBit(logic b);
    sdaM = b;    waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic sendByte(logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    acked = (sdaLine == 1'b0);
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic expectAck(logic [7:0] v, bit want, string tag);
    logic a;
    sendByte(v, a);
    check(a == want, tag, 64'(a), 64'(want));
  endtask

  // R1: reset state
  task automatic tReset();
    for (int g = 0; g < NG; g++) expG[g] = 8'h00;
    checkBank("R1 reset bank");
    check(sdaOeN == 1'b1, "R1 sda released", 64'(sdaOeN), 64'd1);
  endtask

  // R3 R6: full bank write from group 0
  task automatic tFullWrite();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h00, 1, "R5 group 0 ack");
    for (int g = 0; g < NG; g++) begin
      expG[g] = 8'hA1 + 8'(g * 17);
      expectAck(expG[g], 1, "R6 data ack");
    end
    busStop();
    checkBank("R6 full bank");
  endtask

  // R6: start in the middle
  task automatic tMidStart();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h03, 1, "R5 group 3 ack");
    expG[3] = 8'h80; expectAck(8'h80, 1, "R6 data g3");
    expG[4] = 8'h01; expectAck(8'h01, 1, "R6 data g4");
    expG[5] = 8'h5C; expectAck(8'h5C, 1, "R6 data g5");
    busStop();
    checkBank("R6 mid start msb first");
  endtask

  // R7: single byte only
  task automatic tSingle();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h05, 1, "R5 group 5 ack");
    expG[5] = 8'h3E; expectAck(8'h3E, 1, "R7 single data ack");
    busStop();
    checkBank("R7 single group");
  endtask

  // R4: wrong address and read direction
  task automatic tBadAddr();
    busStart();
    expectAck({ADDR ^ 7'h01, 1'b0}, 0, "R4 wrong address nak");
    expectAck(8'h00, 0, "R4 ignored byte");
    expectAck(8'hFF, 0, "R4 ignored byte");
    busStop();
    checkBank("R4 wrong address no effect");
    busStart();
    expectAck({ADDR, 1'b1}, 0, "R4 read direction nak");
    expectAck(8'h01, 0, "R4 ignored byte");
    busStop();
    checkBank("R4 read no effect");
  endtask

  // R5: group index out of range
  task automatic tBadSub();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h06, 0, "R5 index 6 nak");
    expectAck(8'h77, 0, "R5 data ignored");
    busStop();
    checkBank("R5 bad index no effect");
  endtask

  // R8: overflow past group 5
  task automatic tOverflow();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h04, 1, "R5 group 4 ack");
    expG[4] = 8'h44; expectAck(8'h44, 1, "R8 g4 ack");
    expG[5] = 8'h55; expectAck(8'h55, 1, "R8 g5 ack");
    expectAck(8'h99, 0, "R8 past end nak");
    busStop();
    checkBank("R8 no wrap");
  endtask

  // R9: STOP inside a byte
  task automatic tPartial();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h01, 1, "R5 group 1 ack");
    expG[1] = 8'hC3; expectAck(8'hC3, 1, "R9 first byte ack");
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    checkBank("R9 partial discarded");
  endtask

  // R2: repeated START restarts at the address byte
  task automatic tRepStart();
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R3 address ack");
    expectAck(8'h02, 1, "R5 group 2 ack");
    expG[2] = 8'h2B; expectAck(8'h2B, 1, "R2 data before restart");
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    busStart();
    expectAck({ADDR, 1'b0}, 1, "R2 address after restart");
    expectAck(8'h00, 1, "R2 group 0 after restart");
    expG[0] = 8'h0D; expectAck(8'h0D, 1, "R2 data after restart");
    busStop();
    checkBank("R2 repeated start");
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (5) @(negedge clk);
    tReset();
    rstN = 1'b1;
    waitQ(2);
    tFullWrite();
    tMidStart();
    tSingle();
    tBadAddr();
    tBadSub();
    tOverflow();
    tPartial();
    tRepStart();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule